// File: doc/BRIEF.md
# Integer Load Address and Result Formatter

This block carries out one single-register integer load for a 64-bit core. A decoded load arrives in a single cycle: access size, sign-extension and byte-reverse flags, addressing form, update flag, target and base register indices, a 16-bit displacement, and the values of the base and index registers. The block forms the effective address and checks the form for validity. It then issues one read on a valid/ready memory request port and waits for the response. It shapes the returned bytes into a 64-bit register value.

The result goes out on a target write port. For update forms the effective address also goes back to the base register on a second write port in the same cycle. Invalid update forms never reach memory. They raise a one-cycle error flag. Only one load is in flight at a time, and a new load is accepted only while the block is idle.

Top module: `load_fmt_unit`

## Requirements
- R1: For non-update forms the base is zero when `req_ra` is 0; otherwise it is `req_ra_val`.
- R2: With `req_form` 0 the offset is the 16-bit `req_disp` sign-extended to 64 bits. With `req_form` 2 or 3 the offset is `req_rb_val`. `mem_addr` carries base plus offset.
- R3: With `req_form` 1 the offset is `req_disp[15:2]` followed by two zero bits, sign-extended from bit 15. The low two displacement bits have no effect on `mem_addr`.
- R4: `req_size` encodes 1, 2, 4 or 8 bytes as 0, 1, 2, 3. Without sign extension or byte reversal, the loaded bytes fill the low bits of `tgt_data` and every bit above them is 0. An 8-byte load fills all 64 bits. For byte and 8-byte sizes `req_sext` has no effect.
- R5: With `req_sext`=1, `req_brev`=0 and size 1 or 2, every bit above the loaded value equals its most significant bit.
- R6: With `req_brev`=1, the byte at the lowest address becomes the least significant byte of the result. Bits above the loaded bytes are 0 and `req_sext` is ignored.
- R7: Update forms (`req_upd`=1) take `req_ra_val` as base. They write the effective address to register `req_ra` through `base_we`/`base_idx`/`base_data`. Non-update forms never assert `base_we`.
- R8: An update form whose `req_ra` is 0 or equals `req_rt` is invalid. `err` pulses for one cycle, one cycle after acceptance. No memory request and no register write follow.
- R9: `mem_req_valid` rises one cycle after a valid load is accepted. It holds, with `mem_addr` and `mem_size` stable, until `mem_req_ready`. `mem_rsp_data` holds the loaded bytes in its low 8N bits, with the lowest-addressed byte most significant.
- R10: `tgt_we`, `base_we` (update forms) and `done` are high together for exactly one cycle, the cycle after `mem_rsp_valid` is seen. No register write happens before that response.
- R11: `req_ready` is high only while no load is in progress. A load is accepted when `req_valid` and `req_ready` are high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Decoded load present |
| req_ready | output | 1 | Block idle, load can be accepted |
| req_form | input | 2 | 0 signed displacement, 1 scaled displacement, 2/3 indexed |
| req_upd | input | 1 | Update form: write address back to base |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_sext | input | 1 | Sign-extend halfword and word results |
| req_brev | input | 1 | Byte-reverse the loaded value |
| req_rt | input | 5 | Target register index |
| req_ra | input | 5 | Base register index |
| req_disp | input | 16 | Displacement field |
| req_ra_val | input | 64 | Base register value |
| req_rb_val | input | 64 | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Effective address |
| mem_size | output | 2 | Access size, same encoding as req_size |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned, lowest address most significant |
| tgt_we | output | 1 | Target register write |
| tgt_idx | output | 5 | Target register index |
| tgt_data | output | 64 | Shaped load result |
| base_we | output | 1 | Base register write (update forms) |
| base_idx | output | 5 | Base register index |
| base_data | output | 64 | Effective address written back |
| done | output | 1 | Load completed this cycle |
| err | output | 1 | Invalid form rejected this cycle |

## Verification
The assertions assume that memory gives exactly one `mem_rsp_valid` pulse per request, and only after the request handshake. They also assume `mem_rsp_data` is meaningful only in that cycle. The block ignores `mem_rsp_valid` at other times, but the stability and ordering checks rely on a well-behaved responder. The bench drives the memory side as a single-response responder. It adds random stalls on `mem_req_ready` and random latency before the response. It raises `req_valid` only while `req_ready` is high and holds every request field steady across the accepting edge.

// File: rtl/load_fmt_pkg.sv
package load_fmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    AF_DISP   = 2'd0,
    AF_SCALED = 2'd1,
    AF_INDEX  = 2'd2,
    AF_INDEX2 = 2'd3
  } addr_form_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_COMMIT = 3'd3,
    ST_FAULT  = 3'd4
  } ld_state_e;

endpackage

// File: rtl/load_fmt_agen.sv
module load_fmt_agen
  import load_fmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDXW  = 5,
  parameter int DISPW = 16
) (
  input  logic [1:0]      form,
  input  logic            upd,
  input  logic [IDXW-1:0] rt_idx,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [DISPW-1:0] disp,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic [XLEN-1:0] ea,
  output logic            bad_form
);

  localparam int EXTW = XLEN - DISPW;

  // Base: update forms always use the register; others treat index 0 as zero.
  function automatic logic [XLEN-1:0] pick_base(input logic u, input logic [IDXW-1:0] idx,
                                                input logic [XLEN-1:0] v);
    if (u || (idx != '0)) return v;
    return '0;
  endfunction

  function automatic logic [XLEN-1:0] pick_offset(input logic [1:0] f, input logic [DISPW-1:0] d,
                                                  input logic [XLEN-1:0] idxv);
    logic [DISPW-1:0] dd;
    case (addr_form_e'(f))
      AF_DISP:   return {{EXTW{d[DISPW-1]}}, d};
      AF_SCALED: begin
        dd = {d[DISPW-1:2], 2'b00};
        return {{EXTW{dd[DISPW-1]}}, dd};
      end
      default:   return idxv;
    endcase
  endfunction

  logic [XLEN-1:0] base_w;
  logic [XLEN-1:0] off_w;

  assign base_w   = pick_base(upd, ra_idx, ra_val);
  assign off_w    = pick_offset(form, disp, rb_val);
  assign ea       = base_w + off_w;
  assign bad_form = upd && ((ra_idx == '0) || (ra_idx == rt_idx));

endmodule

// File: rtl/load_fmt_shape.sv
module load_fmt_shape
  import load_fmt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic            sext,
  input  logic            brev,
  output logic [XLEN-1:0] shaped
);

  localparam int NB = XLEN / 8;

  // raw holds n bytes right-aligned, lowest address in the top byte of that field.
  function automatic logic [XLEN-1:0] shape(input logic [XLEN-1:0] r, input logic [1:0] sz,
                                            input logic sx, input logic br);
    int n;
    logic [XLEN-1:0] v;
    logic msb;
    n = 1 << sz;
    v = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < n) begin
        if (br) v[i*8 +: 8] = r[(n-1-i)*8 +: 8];
        else    v[i*8 +: 8] = r[i*8 +: 8];
      end
    end
    msb = v[n*8-1];
    if (sx && !br && ((ld_size_e'(sz) == SZ_HALF) || (ld_size_e'(sz) == SZ_WORD))) begin
      for (int b = 0; b < XLEN; b++) begin
        if (b >= n*8) v[b] = msb;
      end
    end
    return v;
  endfunction

  assign shaped = shape(raw, size, sext, brev);

endmodule

// File: rtl/load_fmt_ctrl.sv
module load_fmt_ctrl
  import load_fmt_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_size,
  input  logic            req_sext,
  input  logic            req_brev,
  input  logic            req_upd,
  input  logic [IDXW-1:0] req_rt,
  input  logic [IDXW-1:0] req_ra,
  input  logic [XLEN-1:0] ea_in,
  input  logic            bad_form,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] shaped,
  output logic [1:0]      cur_size,
  output logic            cur_sext,
  output logic            cur_brev,
  output logic            tgt_we,
  output logic [IDXW-1:0] tgt_idx,
  output logic [XLEN-1:0] tgt_data,
  output logic            base_we,
  output logic [IDXW-1:0] base_idx,
  output logic [XLEN-1:0] base_data,
  output logic            done,
  output logic            err
);

  ld_state_e       state_q;
  logic [1:0]      size_q;
  logic            sext_q, brev_q, upd_q;
  logic [IDXW-1:0] rt_q, ra_q;
  logic [XLEN-1:0] addr_q, res_q;

  // Named events for the assertions.
  logic accept_ev, issue_ev, rsp_ev;
  assign accept_ev = req_valid && (state_q == ST_IDLE);
  assign issue_ev  = (state_q == ST_ISSUE) && mem_req_ready;
  assign rsp_ev    = (state_q == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
      sext_q  <= 1'b0;
      brev_q  <= 1'b0;
      upd_q   <= 1'b0;
      rt_q    <= '0;
      ra_q    <= '0;
      addr_q  <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_ev) begin
          size_q  <= req_size;
          sext_q  <= req_sext;
          brev_q  <= req_brev;
          upd_q   <= req_upd;
          rt_q    <= req_rt;
          ra_q    <= req_ra;
          addr_q  <= ea_in;
          state_q <= bad_form ? ST_FAULT : ST_ISSUE;
        end
        ST_ISSUE:  if (issue_ev) state_q <= ST_WAIT;
        ST_WAIT:   if (rsp_ev) begin
          res_q   <= shaped;
          state_q <= ST_COMMIT;
        end
        ST_COMMIT: state_q <= ST_IDLE;
        ST_FAULT:  state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_addr      = addr_q;
  assign mem_size      = size_q;
  assign cur_size      = size_q;
  assign cur_sext      = sext_q;
  assign cur_brev      = brev_q;
  assign tgt_we        = (state_q == ST_COMMIT);
  assign tgt_idx       = rt_q;
  assign tgt_data      = res_q;
  assign base_we       = (state_q == ST_COMMIT) && upd_q;
  assign base_idx      = ra_q;
  assign base_data     = addr_q;
  assign done          = (state_q == ST_COMMIT);
  assign err           = (state_q == ST_FAULT);

  a_r8_bad_goes_fault: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && bad_form |=> err && !mem_req_valid);
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !mem_req_valid && !tgt_we && !base_we);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_size));
  a_r10_write_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |-> $past(mem_rsp_valid));
  a_r10_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tgt_we && !err);
  a_r7_base_idx_legal: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (base_idx != '0) && (base_idx != tgt_idx));
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we && (size_q == 2'd0) |-> (tgt_data[XLEN-1:8] == '0));
  a_r5_half_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we && (size_q == 2'd1) && sext_q && !brev_q |->
      (tgt_data[XLEN-1:16] == {(XLEN-16){tgt_data[15]}}));
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);

endmodule

// File: rtl/load_fmt_unit.sv
module load_fmt_unit
  import load_fmt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDXW  = 5,
  parameter int DISPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_form,
  input  logic             req_upd,
  input  logic [1:0]       req_size,
  input  logic             req_sext,
  input  logic             req_brev,
  input  logic [IDXW-1:0]  req_rt,
  input  logic [IDXW-1:0]  req_ra,
  input  logic [DISPW-1:0] req_disp,
  input  logic [XLEN-1:0]  req_ra_val,
  input  logic [XLEN-1:0]  req_rb_val,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_addr,
  output logic [1:0]       mem_size,
  input  logic             mem_rsp_valid,
  input  logic [XLEN-1:0]  mem_rsp_data,
  output logic             tgt_we,
  output logic [IDXW-1:0]  tgt_idx,
  output logic [XLEN-1:0]  tgt_data,
  output logic             base_we,
  output logic [IDXW-1:0]  base_idx,
  output logic [XLEN-1:0]  base_data,
  output logic             done,
  output logic             err
);

  logic [XLEN-1:0] ea_w;
  logic            bad_w;
  logic [XLEN-1:0] shaped_w;
  logic [1:0]      cur_size_w;
  logic            cur_sext_w, cur_brev_w;

  load_fmt_agen #(.XLEN(XLEN), .IDXW(IDXW), .DISPW(DISPW)) u_agen (
    .form     (req_form),
    .upd      (req_upd),
    .rt_idx   (req_rt),
    .ra_idx   (req_ra),
    .disp     (req_disp),
    .ra_val   (req_ra_val),
    .rb_val   (req_rb_val),
    .ea       (ea_w),
    .bad_form (bad_w)
  );

  load_fmt_shape #(.XLEN(XLEN)) u_shape (
    .raw    (mem_rsp_data),
    .size   (cur_size_w),
    .sext   (cur_sext_w),
    .brev   (cur_brev_w),
    .shaped (shaped_w)
  );

  load_fmt_ctrl #(.XLEN(XLEN), .IDXW(IDXW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_size      (req_size),
    .req_sext      (req_sext),
    .req_brev      (req_brev),
    .req_upd       (req_upd),
    .req_rt        (req_rt),
    .req_ra        (req_ra),
    .ea_in         (ea_w),
    .bad_form      (bad_w),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_size      (mem_size),
    .mem_rsp_valid (mem_rsp_valid),
    .shaped        (shaped_w),
    .cur_size      (cur_size_w),
    .cur_sext      (cur_sext_w),
    .cur_brev      (cur_brev_w),
    .tgt_we        (tgt_we),
    .tgt_idx       (tgt_idx),
    .tgt_data      (tgt_data),
    .base_we       (base_we),
    .base_idx      (base_idx),
    .base_data     (base_data),
    .done          (done),
    .err           (err)
  );

endmodule

// File: tb/load_fmt_unit_tb.sv
module load_fmt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_form = '0;
  logic        req_upd = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_sext = 1'b0;
  logic        req_brev = 1'b0;
  logic [4:0]  req_rt = '0;
  logic [4:0]  req_ra = '0;
  logic [15:0] req_disp = '0;
  logic [63:0] req_ra_val = '0;
  logic [63:0] req_rb_val = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        tgt_we;
  logic [4:0]  tgt_idx;
  logic [63:0] tgt_data;
  logic        base_we;
  logic [4:0]  base_idx;
  logic [63:0] base_data;
  logic        done;
  logic        err;

  always #5 clk = ~clk;

  load_fmt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_form(req_form), .req_upd(req_upd), .req_size(req_size), .req_sext(req_sext),
    .req_brev(req_brev), .req_rt(req_rt), .req_ra(req_ra), .req_disp(req_disp),
    .req_ra_val(req_ra_val), .req_rb_val(req_rb_val), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .tgt_we(tgt_we),
    .tgt_idx(tgt_idx), .tgt_data(tgt_data), .base_we(base_we), .base_idx(base_idx),
    .base_data(base_data), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Memory contents as a function of address.
  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3 ^ {a[19:16], a[19:16]};
  endfunction

  function automatic logic [63:0] exp_ea(input logic [1:0] f, input logic u, input logic [4:0] ra,
                                         input logic [15:0] d, input logic [63:0] rav,
                                         input logic [63:0] rbv);
    logic [63:0] b, o;
    b = (u || ra != 0) ? rav : 64'd0;
    if (f >= 2)      o = rbv;
    else if (f == 0) o = 64'($signed(d));
    else             o = 64'($signed(d)) & ~64'd3;
    return b + o;
  endfunction

  function automatic logic [63:0] exp_val(input logic [63:0] ea, input logic [1:0] sz,
                                          input logic sx, input logic br);
    int n;
    logic [63:0] v;
    logic signed [63:0] s;
    n = 1 << sz;
    v = 0;
    if (br) for (int i = 0; i < n; i++) v = v | (64'(mbyte(ea + 64'(i))) << (8*i));
    else    for (int i = 0; i < n; i++) v = (v << 8) | 64'(mbyte(ea + 64'(i)));
    if (sx && !br && (n == 2 || n == 4)) begin
      s = $signed(v << (64 - 8*n));
      v = s >>> (64 - 8*n);
    end
    return v;
  endfunction

  function automatic logic [63:0] rsp_image(input logic [63:0] ea, input logic [1:0] sz);
    int n;
    logic [63:0] v;
    n = 1 << sz;
    v = 0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(mbyte(ea + 64'(i)));
    return v;
  endfunction

  // Reference model: phase 0 idle, 1 request, 2 await data, 3 write, 4 error.
  int          ph = 0;
  logic [63:0] m_ea, m_val;
  logic [1:0]  m_size;
  logic        m_upd;
  logic [4:0]  m_rt, m_ra;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
        m_ea   = exp_ea(req_form, req_upd, req_ra, req_disp, req_ra_val, req_rb_val);
        m_val  = exp_val(m_ea, req_size, req_sext, req_brev);
        m_size = req_size;
        m_upd  = req_upd;
        m_rt   = req_rt;
        m_ra   = req_ra;
        ph = (req_upd && (req_ra == 0 || req_ra == req_rt)) ? 4 : 1;
      end
      1: if (mem_req_ready) ph = 2;
      2: if (mem_rsp_valid) ph = 3;
      default: ph = 0;
    endcase
  end

  always @(negedge clk) begin
    #1;
    chk(req_ready == (ph == 0), "R11 req_ready", 64'(req_ready), 64'(ph == 0));
    chk(mem_req_valid == (ph == 1), "R9 mem_req_valid", 64'(mem_req_valid), 64'(ph == 1));
    chk(err == (ph == 4), "R8 err", 64'(err), 64'(ph == 4));
    chk(done == (ph == 3), "R10 done", 64'(done), 64'(ph == 3));
    chk(tgt_we == (ph == 3), "R10 tgt_we", 64'(tgt_we), 64'(ph == 3));
    chk(base_we == (ph == 3 && m_upd), "R7 base_we", 64'(base_we), 64'(ph == 3 && m_upd));
    if (ph == 1) begin
      chk(mem_addr == m_ea, "R1 R2 R3 mem_addr", mem_addr, m_ea);
      chk(mem_size == m_size, "R9 mem_size", 64'(mem_size), 64'(m_size));
    end
    if (ph == 3) begin
      chk(tgt_data == m_val, "R4 R5 R6 tgt_data", tgt_data, m_val);
      chk(tgt_idx == m_rt, "R10 tgt_idx", 64'(tgt_idx), 64'(m_rt));
      if (m_upd) begin
        chk(base_idx == m_ra, "R7 base_idx", 64'(base_idx), 64'(m_ra));
        chk(base_data == m_ea, "R7 base_data", base_data, m_ea);
      end
    end
  end

  task automatic run_op(input logic [1:0] f, input logic u, input logic [1:0] sz, input logic sx,
                        input logic br, input logic [4:0] rt, input logic [4:0] ra,
                        input logic [15:0] d, input logic [63:0] rav, input logic [63:0] rbv,
                        input int stall, input int lat);
    logic [63:0] ea;
    while (!req_ready) @(negedge clk);
    req_form = f; req_upd = u; req_size = sz; req_sext = sx; req_brev = br;
    req_rt = rt; req_ra = ra; req_disp = d; req_ra_val = rav; req_rb_val = rbv;
    req_valid = 1'b1;
    ea = exp_ea(f, u, ra, d, rav, rbv);
    @(negedge clk);
    req_valid = 1'b0;
    req_ra_val = 64'hDEAD_BEEF_0BAD_F00D;
    if (u && (ra == 0 || ra == rt)) begin
      repeat (2) @(negedge clk);
    end else begin
      repeat (stall) @(negedge clk);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      repeat (lat) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rsp_image(ea, sz);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk(req_ready && !mem_req_valid && !tgt_we && !base_we && !done && !err,
        "R11 reset state", {58'd0, req_ready, mem_req_valid, tgt_we, base_we, done, err}, 64'h20);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: base index 0 means zero base (non-update)
    run_op(2'd0, 0, 2'd3, 0, 0, 5'd3, 5'd0, 16'h0040, 64'h1234_0000, 64'h0, 0, 0);
    // R2: negative displacement, indexed form
    run_op(2'd0, 0, 2'd2, 0, 0, 5'd4, 5'd7, 16'hFFF0, 64'h0000_0000_0010_0100, 64'h0, 1, 2);
    run_op(2'd2, 0, 2'd1, 0, 0, 5'd4, 5'd7, 16'h7FFF, 64'h0000_0000_0002_0000, 64'h33, 0, 1);
    run_op(2'd3, 0, 2'd0, 0, 0, 5'd4, 5'd0, 16'h0, 64'h55, 64'h0000_0000_0003_1111, 2, 0);
    // R3: scaled displacement with low bits set and negative
    run_op(2'd1, 0, 2'd3, 0, 0, 5'd9, 5'd2, 16'h0007, 64'h2000, 64'h0, 0, 0);
    run_op(2'd1, 0, 2'd3, 0, 0, 5'd9, 5'd2, 16'h8003, 64'h0004_0000, 64'h0, 0, 0);
    // R4 byte with sext set (no effect), R5 signed half/word, R6 reversed
    run_op(2'd0, 0, 2'd0, 1, 0, 5'd1, 5'd2, 16'h0011, 64'h300, 64'h0, 0, 0);
    run_op(2'd0, 0, 2'd1, 1, 0, 5'd1, 5'd2, 16'h0002, 64'h0A0, 64'h0, 0, 0);
    run_op(2'd0, 0, 2'd2, 1, 0, 5'd1, 5'd2, 16'h0006, 64'h780, 64'h0, 0, 0);
    run_op(2'd2, 0, 2'd1, 1, 1, 5'd1, 5'd2, 16'h0, 64'h4400, 64'h2, 0, 0);
    run_op(2'd2, 0, 2'd2, 0, 1, 5'd1, 5'd2, 16'h0, 64'h4400, 64'h9, 0, 0);
    run_op(2'd2, 0, 2'd3, 0, 1, 5'd1, 5'd2, 16'h0, 64'h4400, 64'h21, 0, 0);
    // R7 update forms, R8 invalid update forms
    run_op(2'd0, 1, 2'd2, 0, 0, 5'd6, 5'd5, 16'h0100, 64'h8000, 64'h0, 1, 1);
    run_op(2'd2, 1, 2'd3, 0, 0, 5'd6, 5'd5, 16'h0, 64'h8000, 64'hFFFF_FFFF_FFFF_FFF8, 0, 3);
    run_op(2'd0, 1, 2'd2, 0, 0, 5'd6, 5'd0, 16'h0100, 64'h8000, 64'h0, 0, 0);
    run_op(2'd2, 1, 2'd0, 0, 0, 5'd8, 5'd8, 16'h0, 64'h8000, 64'h4, 0, 0);
    // Randomised mix
    for (int k = 0; k < 400; k++) begin
      run_op(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
             5'($urandom), 5'($urandom % 4), 16'($urandom),
             {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
             int'($urandom % 4), int'($urandom % 4));
    end
    repeat (3) @(negedge clk);
    report();
  end

endmodule